// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block sits between a request queue and the command pins of an SDRAM controller. Each cycle it looks at the request at the head of the queue: a read, or a write carrying a four-beat burst of data with per-byte masks. It turns that request into a device command, together with the byte-mask, data-out-enable and write-data signals. Reads are issued at once. A write that follows a read whose data is still due on the shared data bus is held back. While it is held, the mask is driven high so that the device stops driving the remaining read words. The write is then issued only once the bus has been quiet for at least one cycle.

The read latency is set by the `cas_lat3` input, which selects 2 or 3 cycles, and each read is tracked with the latency in force when it was issued. A read word that would otherwise appear on the bus is suppressed when the mask was high two cycles before that word. A write command ends any read burst still in progress. All outputs are registered, so every command and bus signal appears one cycle after the cycle in which the request was accepted.

Top module: `sdram_rw_turnaround`

## Requirements
- R1: After reset, and in every cycle with nothing to issue, `cmd` is NOP, `dq_oe` is 0 and `dqm` is 0. The command codes are NOP=2'b00, READ=2'b01 and WRITE=2'b10.
- R2: A read request is accepted in the cycle it is presented (`req_ready`=1). In the next cycle `cmd` is READ, carrying that request's bank and column. Consecutive reads are issued in consecutive cycles, with no gap.
- R3: A write request is issued immediately when no read word is due within the next two output cycles, that is, when the last read word falls at least two cycles before the write command.
- R4: A read issued on output cycle r delivers its words on cycles r+CL through r+CL+3. CL is 3 when `cas_lat3`=1 and 2 otherwise, sampled when the read is accepted.
- R5: Otherwise the write is issued at whichever comes first: three cycles after it first waits, or the cycle after the read data ends on its own. At least one idle bus cycle always separates the last read word that is driven from the write command.
- R6: While a write waits, `dqm` is all ones. Every read word due on cycle w-1 or w, where w is the write command cycle, has `dqm` high two cycles before it.
- R7: A read word due on cycle w+1 (the second write beat) is also suppressed by `dqm` being high two cycles earlier. During every waiting cycle `cmd` is NOP.
- R8: `dq_oe` is high on exactly the four cycles w..w+3 and at no other time. `dq_out` carries beat i from `req_wdata[i*DATA_W +: DATA_W]`, with beat 0 on the command cycle.
- R9: On beat i, `dqm` equals `req_wmask[i*BYTES +: BYTES]`. It returns to 0 on the cycle after the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | 1 selects read latency 3, 0 selects 2 |
| req_valid | input | 1 | Head request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_wdata | input | BURST*DATA_W | Write burst data, beat 0 in low bits |
| req_wmask | input | BURST*DATA_W/8 | Per-byte write mask, beat 0 in low bits |
| req_ready | output | 1 | Head request is taken this cycle |
| cmd | output | 2 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_col | output | COL_W | Command column |
| dqm | output | DATA_W/8 | Byte mask to the device |
| dq_oe | output | 1 | Controller drives the data bus |
| dq_out | output | DATA_W | Write data |

## Verification
A read command is due one cycle after its request is presented. A write command is due one cycle after the issue cycle, which the bench computes from the last read's issue cycle, its latency and the write's arrival. The write's four data beats follow on that cycle and the three after it, and the mask must be back at zero on the fifth. The scoreboard stamps each expected command with the cycle it is due and compares the cycle in which it actually appears. On every write it looks up the recorded mask from two cycles before each read word that overlaps the write. All outputs are sampled on the falling edge, half a cycle after the registers update.

// File: rtl/sdram_ta_pkg.sv
package sdram_ta_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10
  } cmd_e;

  // mask must lead a truncating write by the mask-to-output latency (2) plus one idle cycle
  localparam int unsigned MASK_LEAD = 3;
endpackage

// File: rtl/rd_bus_tracker.sv
module rd_bus_tracker #(
  parameter int unsigned BURST = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic             wr_go,
  input  logic             cl3,
  output logic [CNT_W-1:0] busy
);
  // busy == 0 means the last read word lies two or more cycles in the past
  logic [CNT_W-1:0] busy_q, busy_d;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(BURST + (cl3 ? 3 : 2));
    busy_d   = busy_q;
    if (rd_go)              busy_d = load_val;
    else if (wr_go)         busy_d = '0;
    else if (busy_q != '0)  busy_d = busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/mask_lead_ctr.sv
module mask_lead_ctr
  import sdram_ta_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic lead_met
);
  localparam int unsigned RW = $clog2(MASK_LEAD + 1);
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    run_d = '0;
    if (hold) run_d = (run_q == RW'(MASK_LEAD)) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign lead_met = (run_q == RW'(MASK_LEAD));
endmodule

// File: rtl/wr_burst_gen.sv
module wr_burst_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BURST  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        cancel,
  input  logic [BURST*DATA_W-1:0]     wdata,
  input  logic [BURST*DATA_W/8-1:0]   wmask,
  output logic                        active,
  output logic [DATA_W-1:0]           beat_data,
  output logic [DATA_W/8-1:0]         beat_mask
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned BW    = (BURST > 1) ? $clog2(BURST) : 1;

  logic [BW-1:0]               beat_q, beat_d;
  logic [BURST*DATA_W-1:0]     data_q;
  logic [BURST*BYTES-1:0]      mask_q;
  logic                        load_en;

  // beat_q holds the index of the next beat still to drive; 0 means idle
  always_comb begin
    load_en = start;
    beat_d  = beat_q;
    if (start)                          beat_d = (BURST > 1) ? BW'(1) : '0;
    else if (cancel)                    beat_d = '0;
    else if (beat_q != '0)              beat_d = (beat_q == BW'(BURST-1)) ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      beat_q <= beat_d;
      if (load_en) begin
        data_q <= wdata;
        mask_q <= wmask;
      end
    end
  end

  assign active    = (beat_q != '0);
  assign beat_data = data_q[beat_q*DATA_W +: DATA_W];
  assign beat_mask = mask_q[beat_q*BYTES +: BYTES];
endmodule

// File: rtl/sdram_rw_turnaround.sv
module sdram_rw_turnaround
  import sdram_ta_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned BURST  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cas_lat3,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic [COL_W-1:0]           req_col,
  input  logic [BURST*DATA_W-1:0]    req_wdata,
  input  logic [BURST*DATA_W/8-1:0]  req_wmask,
  output logic                       req_ready,
  output logic [1:0]                 cmd,
  output logic [BANK_W-1:0]          cmd_bank,
  output logic [COL_W-1:0]           cmd_col,
  output logic [DATA_W/8-1:0]        dqm,
  output logic                       dq_oe,
  output logic [DATA_W-1:0]          dq_out
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned CNT_W = $clog2(BURST + 4);

  logic [CNT_W-1:0]  busy;
  logic              lead_met, wr_ok;
  logic              issue_rd, issue_wr, hold;
  logic              beat_act, beat_use;
  logic [DATA_W-1:0] beat_data;
  logic [BYTES-1:0]  beat_mask;

  cmd_e              cmd_d, cmd_q;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic [COL_W-1:0]  col_d, col_q;
  logic [BYTES-1:0]  dqm_d, dqm_q;
  logic              oe_d, oe_q;
  logic [DATA_W-1:0] dout_d, dout_q;

  assign wr_ok     = (busy == '0) || lead_met;
  assign issue_rd  = req_valid && !req_write;
  assign issue_wr  = req_valid && req_write && wr_ok;
  assign hold      = req_valid && req_write && !wr_ok;
  assign req_ready = !req_write || wr_ok;
  assign beat_use  = beat_act && !issue_rd;

  rd_bus_tracker #(.BURST(BURST), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .rd_go(issue_rd), .wr_go(issue_wr),
    .cl3(cas_lat3), .busy(busy)
  );

  mask_lead_ctr u_lead (
    .clk(clk), .rst_n(rst_n), .hold(hold), .lead_met(lead_met)
  );

  wr_burst_gen #(.DATA_W(DATA_W), .BURST(BURST)) u_wgen (
    .clk(clk), .rst_n(rst_n), .start(issue_wr), .cancel(issue_rd),
    .wdata(req_wdata), .wmask(req_wmask), .active(beat_act),
    .beat_data(beat_data), .beat_mask(beat_mask)
  );

  always_comb begin
    cmd_d  = CMD_NOP;
    bank_d = '0;
    col_d  = '0;
    dqm_d  = '0;
    oe_d   = 1'b0;
    dout_d = '0;
    if (issue_rd) begin
      cmd_d  = CMD_READ;
      bank_d = req_bank;
      col_d  = req_col;
    end else if (issue_wr) begin
      cmd_d  = CMD_WRITE;
      bank_d = req_bank;
      col_d  = req_col;
      dqm_d  = req_wmask[BYTES-1:0];
      oe_d   = 1'b1;
      dout_d = req_wdata[DATA_W-1:0];
    end else if (beat_use) begin
      dqm_d  = beat_mask;
      oe_d   = 1'b1;
      dout_d = beat_data;
    end else if (hold) begin
      dqm_d  = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      col_q  <= '0;
      dqm_q  <= '0;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      col_q  <= col_d;
      dqm_q  <= dqm_d;
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign cmd      = cmd_q;
  assign cmd_bank = bank_q;
  assign cmd_col  = col_q;
  assign dqm      = dqm_q;
  assign dq_oe    = oe_q;
  assign dq_out   = dout_q;

  p_read_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (cmd == 2'b01));

  p_wait_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cmd == 2'b00));

  p_wait_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (dqm == {BYTES{1'b1}}));

  p_write_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |-> dq_oe);

  // truncating write needs three masked waiting cycles just before it
  p_mask_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_wr && busy != '0) |-> ($past(hold) && $past(hold, 2) && $past(hold, 3)));
endmodule

// File: tb/sim_sdram_rw_turnaround.sv
`timescale 1ns/1ps
module sim_sdram_rw_turnaround;
  localparam int DW = 32;
  localparam int BL = 4;
  localparam int NB = DW / 8;

  typedef struct {
    logic [1:0]       kind;
    logic [1:0]       bank;
    logic [8:0]       col;
    int               due;
    int               cl;
    logic [BL*DW-1:0] data;
    logic [BL*NB-1:0] mask;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cas_lat3;
  logic req_valid, req_write;
  logic [1:0] req_bank;
  logic [8:0] req_col;
  logic [BL*DW-1:0] req_wdata;
  logic [BL*NB-1:0] req_wmask;
  logic req_ready;
  logic [1:0] cmd;
  logic [1:0] cmd_bank;
  logic [8:0] cmd_col;
  logic [NB-1:0] dqm;
  logic dq_oe;
  logic [DW-1:0] dq_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  exp_t sb[$];

  // bench-side model of the last read (issue-cycle frame)
  int rd_t = 0; int rd_cl = 2; bit rd_v = 0;

  // monitor state (output frame)
  bit hist[32];
  int mon_r = 0; int mon_cl = 2; bit mon_rv = 0;
  int wb = 5; exp_t cur;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_rw_turnaround u0 (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
    .req_wdata(req_wdata), .req_wmask(req_wmask), .req_ready(req_ready),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .dqm(dqm),
    .dq_oe(dq_oe), .dq_out(dq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_read(input logic [1:0] b, input logic [8:0] c);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_bank = b; req_col = c;
    #0.5;
    chk(req_ready, "R2 ready", req_ready, 1);
    e.kind = 2'b01; e.bank = b; e.col = c; e.due = cyc + 1;
    e.cl = cas_lat3 ? 3 : 2; e.data = '0; e.mask = '0;
    sb.push_back(e);
    rd_t = cyc; rd_cl = e.cl; rd_v = 1;
    @(posedge clk); #0.5;
    req_valid = 0;
  endtask

  task automatic do_write(input logic [1:0] b, input logic [8:0] c,
                          input logic [BL*DW-1:0] d, input logic [BL*NB-1:0] m);
    exp_t e; int a; int last; int ci;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_bank = b; req_col = c;
    req_wdata = d; req_wmask = m;
    a = cyc;
    last = rd_t + rd_cl + 3;
    if (!rd_v || last <= a - 2) ci = a;          // R3
    else ci = (last + 2 < a + 3) ? last + 2 : a + 3; // R5
    e.kind = 2'b10; e.bank = b; e.col = c; e.due = ci + 1;
    e.cl = 0; e.data = d; e.mask = m;
    sb.push_back(e);
    rd_v = 0;
    #0.5;
    while (!req_ready) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5;
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      hist[cyc % 32] = (dqm == {NB{1'b1}});
      if (cmd != 2'b00) begin
        if (sb.size() == 0) begin
          chk(0, "R7 unexpected command", cmd, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cmd == e.kind, "R2/R3 command kind", cmd, e.kind);
          chk(cmd_bank == e.bank && cmd_col == e.col, "R2 bank/col", {cmd_bank, cmd_col}, {e.bank, e.col});
          chk(cyc == e.due, (e.kind == 2'b01) ? "R2 read cycle" : "R3/R5/R7 write cycle", cyc, e.due);
          if (cmd == 2'b01) begin
            mon_r = cyc; mon_cl = e.cl; mon_rv = 1;
          end else if (cmd == 2'b10) begin
            // R4 window of read words; R6 covers w-1 and w, R7 covers w+1
            if (mon_rv) begin
              for (int k = cyc - 1; k <= cyc + 1; k++) begin
                if (k >= mon_r + mon_cl && k <= mon_r + mon_cl + 3)
                  chk(hist[(k - 2) % 32], (k <= cyc) ? "R4/R5/R6 read word masked" : "R7 word on second beat masked",
                      hist[(k - 2) % 32], 1);
              end
            end
            mon_rv = 0;
            cur = e; wb = 0;
          end
        end
      end
      if (wb < BL) begin
        chk(dq_oe, "R8 oe during beat", dq_oe, 1);
        chk(dq_out == cur.data[wb*DW +: DW], "R8 beat data", dq_out, cur.data[wb*DW +: DW]);
        chk(dqm == cur.mask[wb*NB +: NB], "R9 beat mask", dqm, cur.mask[wb*NB +: NB]);
        wb++;
      end else if (wb == BL) begin
        chk(dqm == '0, "R9 mask released", dqm, 0);
        chk(!dq_oe, "R8 oe released", dq_oe, 0);
        wb++;
      end else if (dq_oe) begin
        chk(0, "R8 oe outside write", dq_oe, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cas_lat3 = 0; req_valid = 0; req_write = 0;
    req_bank = 0; req_col = 0; req_wdata = '0; req_wmask = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd == 2'b00 && !dq_oe && dqm == '0, "R1 reset state", {cmd, dq_oe, dqm}, 0);
    chk(req_ready, "R1 ready when idle", req_ready, 1);

    // latency 2
    do_read(2'd0, 9'd10);
    do_write(2'd1, 9'd20, 128'h44444444_33333333_22222222_11111111, '0);
    idle(8);
    do_read(2'd2, 9'd30);
    do_read(2'd3, 9'd40);
    idle(3);
    do_write(2'd0, 9'd50, 128'hdddd0004_cccc0003_bbbb0002_aaaa0001, 16'h0f30);
    idle(8);
    do_write(2'd1, 9'd60, 128'h0badf00d_12345678_9abcdef0_cafef00d, 16'h8001);
    idle(8);
    do_read(2'd1, 9'd70);
    idle(4);
    do_write(2'd2, 9'd71, 128'h1_00000002_00000003_00000004, '0);
    idle(8);

    // latency 3
    cas_lat3 = 1;
    do_read(2'd3, 9'd80);
    do_write(2'd3, 9'd81, 128'hfeedbeef_0000ffff_ffff0000_5a5aa5a5, '0);
    idle(8);
    do_read(2'd0, 9'd90);
    idle(5);
    do_write(2'd1, 9'd91, 128'h77777777_66666666_55555555_01010101, 16'h00ff);
    idle(8);
    do_read(2'd2, 9'd95);
    do_read(2'd2, 9'd96);
    do_read(2'd2, 9'd97);
    do_write(2'd2, 9'd98, 128'h0f0f0f0f_f0f0f0f0_00ff00ff_ff00ff00, 16'hf000);
    idle(10);

    chk(sb.size() == 0, "R2/R5 all commands seen", sb.size(), 0);
    chk(cmd == 2'b00 && dqm == '0 && !dq_oe, "R1 idle state", {cmd, dq_oe, dqm}, 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule